// File: doc/BRIEF.md
# Temperature Sensor Register Slave

This block sits behind a byte-level two-wire bus front end and gives a bus master access to the register set of an on-chip temperature sensor. The front end handles bit timing on SCL and SDA. It passes the block one-cycle strobes for start or repeated start, for stop, for each received byte, and for each byte it loads for transmission. The block decides whether each received byte is acknowledged and supplies the byte to send.

Every access begins with an address byte. Its top nibble selects the sensor function and the next three bits must match the board strap inputs. A write access then delivers an 8-bit pointer, and optionally a high and a low data byte for the selected 16-bit register. A read access returns the selected register high byte first. The pointer keeps its value across accesses, so a read can reuse the pointer set by an earlier access. The live temperature comes in on a port. The block compares it against three trip limits and reports the results in the top bits of the temperature word.

Top module: `tsens_regif`

## Requirements
- R1: A received address byte is acknowledged only when bits 7:4 equal 0011 and bits 3:1 equal `addr_sel_i`. A byte that does not match is not acknowledged, and neither is any later byte until the next start or stop. Such an access changes no register and no pointer.
- R2: After a write-direction address byte (bit 0 = 0), the next byte loads the 8-bit pointer. The pointer resets to 00h and keeps its value across stops and starts. A read without a preceding pointer byte uses the last pointer.
- R3: The two bytes after the pointer form one word, high byte first. The word is written when the second byte arrives. Further bytes in the same access are acknowledged and discarded.
- R4: After a read-direction address byte (bit 0 = 1) is accepted, `tx_byte_o` shows the high byte of the selected register. Each `tx_take_i` strobe moves to the other byte. The word is captured when the address byte is accepted, so a change of `temp_i` after that point does not alter the bytes being returned.
- R5: Pointer 00h returns the capability constant (default 0057h, bits 15:8 zero). It is read-only.
- R6: Pointer 01h is the configuration word. Bits 10:0 are writable, bits 15:11 always read zero, and it resets to 0000h.
- R7: Pointers 02h, 03h and 04h are the upper, lower and critical trip limits. Only bits 12:2 are stored and the other bits read zero. Each resets to 0000h.
- R8: Pointer 05h is read-only. Bits 12:0 carry `temp_i` as 13-bit two's complement in 1/16 degree steps. Bit 15 is set when the temperature is above the critical limit, bit 14 when it is above the upper limit, and bit 13 when it is below the lower limit. All comparisons are signed, and equality sets no flag.
- R9: Pointer 06h reads the manufacturer identity 001Fh and is read-only.
- R10: Pointer 22h is the bus-timeout control. Only bit 7 is writable, and it resets to 0.
- R11: A write to a read-only or unmapped pointer is acknowledged and changes nothing. A read from an unmapped pointer returns 0000h.
- R12: A start or stop strobe returns the block to the address phase. A write cut off after its high byte leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel_i | input | 3 | Board strap bits matched against address bits 3:1 |
| temp_i | input | 13 | Live temperature, two's complement, 1/16 degree per LSB |
| bus_start_i | input | 1 | Strobe: start or repeated start seen |
| bus_stop_i | input | 1 | Strobe: stop seen |
| rx_vld_i | input | 1 | Strobe: a byte from the master is in `rx_byte_i` |
| rx_byte_i | input | 8 | Byte received from the master |
| rx_ack_o | output | 1 | Acknowledge decision for the byte in `rx_byte_i` |
| tx_take_i | input | 1 | Strobe: front end has loaded `tx_byte_o` for sending |
| tx_byte_o | output | 8 | Next byte to send in a read (FFh outside a read) |

## Verification
The bench checks the signed trip flags at both sides of each limit, including equality. A design that compared unsigned values would flag a negative temperature as above the upper limit. It checks that writes to the temperature, identity and unmapped pointers change nothing, and that reserved bits read zero after all-ones writes. A design that got these wrong would read back stray ones. It changes the temperature between address acceptance and byte transfer, which catches a design that reads the live value instead of the captured word. It cuts a write short with a stop and reuses the pointer in a later read, which exposes a design that writes on the high byte or clears the pointer at stop.

// File: rtl/tsreg_pkg.sv
package tsreg_pkg;
   localparam int DW      = 16;
   localparam int FIELD_W = 13;
   localparam logic [3:0] TS_DEVTYPE = 4'b0011;

   localparam logic [7:0] P_CAP = 8'h00;
   localparam logic [7:0] P_CFG = 8'h01;
   localparam logic [7:0] P_UPR = 8'h02;
   localparam logic [7:0] P_LWR = 8'h03;
   localparam logic [7:0] P_CRT = 8'h04;
   localparam logic [7:0] P_TMP = 8'h05;
   localparam logic [7:0] P_MFG = 8'h06;
   localparam logic [7:0] P_TMO = 8'h22;

   typedef enum logic [2:0] {
      PH_ADDR, PH_PTR, PH_WHI, PH_WLO, PH_WSINK, PH_READ, PH_SKIP
   } phase_e;
endpackage

// File: rtl/tsreg_xact.sv
module tsreg_xact
   import tsreg_pkg::*;
#(
   parameter int PTR_W = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] addr_sel,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic             rx_vld,
   input  logic [7:0]       rx_byte,
   input  logic             tx_take,
   input  logic [DW-1:0]    rd_word,
   output logic             rx_ack,
   output logic [7:0]       tx_byte,
   output logic [PTR_W-1:0] ptr,
   output logic             wr_en,
   output logic [DW-1:0]    wr_data
);
   localparam int SEL_LSB = 1;

   if (PTR_W != 8) begin : g_chk_ptr
      $error("tsreg_xact: PTR_W must be 8");
   end
   if (SEL_W + SEL_LSB > 4) begin : g_chk_sel
      $error("tsreg_xact: SEL_W too wide for address byte");
   end

   phase_e     ph;
   logic       rd_lo;
   logic [7:0] hold;
   logic [DW-1:0] snap;
   logic       match;
   logic       abort;

   assign abort = bus_start | bus_stop;
   assign match = (rx_byte[7:4] == TS_DEVTYPE) &&
                  (rx_byte[SEL_LSB +: SEL_W] == addr_sel);

   always_comb begin
      case (ph)
         PH_ADDR:                          rx_ack = match;
         PH_PTR, PH_WHI, PH_WLO, PH_WSINK: rx_ack = 1'b1;
         default:                          rx_ack = 1'b0;
      endcase
   end

   assign wr_en   = rx_vld && !abort && (ph == PH_WLO);
   assign wr_data = {hold, rx_byte};
   assign tx_byte = (ph != PH_READ) ? 8'hFF : (rd_lo ? snap[7:0] : snap[15:8]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_ADDR;
         rd_lo <= 1'b0;
         hold  <= '0;
         snap  <= '0;
         ptr   <= '0;
      end else if (abort) begin
         ph    <= PH_ADDR;
         rd_lo <= 1'b0;
      end else if (rx_vld) begin
         case (ph)
            PH_ADDR: begin
               if (!match) begin
                  ph <= PH_SKIP;
               end else if (rx_byte[0]) begin
                  ph    <= PH_READ;
                  snap  <= rd_word;
                  rd_lo <= 1'b0;
               end else begin
                  ph <= PH_PTR;
               end
            end
            PH_PTR: begin
               ptr <= rx_byte;
               ph  <= PH_WHI;
            end
            PH_WHI: begin
               hold <= rx_byte;
               ph   <= PH_WLO;
            end
            PH_WLO:  ph <= PH_WSINK;
            default: ph <= ph;
         endcase
      end else if (tx_take && ph == PH_READ) begin
         rd_lo <= ~rd_lo;
      end
   end

   assert_abort_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (ph == PH_ADDR));
   assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld && ph == PH_ADDR && rx_byte[7:4] != TS_DEVTYPE) |-> !rx_ack);
   assert_skip_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_SKIP) |-> !rx_ack);
   assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_vld && !abort && ph == PH_PTR) |=> $stable(ptr));
   assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld && !abort && ph == PH_ADDR && match && rx_byte[0]) |=>
      (tx_byte == snap[15:8]));
   assert_snap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_READ && !abort) |=> $stable(snap));
endmodule

// File: rtl/tsreg_file.sv
module tsreg_file
   import tsreg_pkg::*;
#(
   parameter int          PTR_W    = 8,
   parameter int          TEMP_W   = 13,
   parameter int          TRIP_LSB = 2,
   parameter logic [15:0] CAP_VAL  = 16'h0057,
   parameter logic [15:0] MFG_ID   = 16'h001F,
   parameter logic [15:0] CFG_MASK = 16'h07FF,
   parameter logic [15:0] TMO_MASK = 16'h0080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PTR_W-1:0]  ptr,
   input  logic              wr_en,
   input  logic [DW-1:0]     wr_data,
   input  logic [TEMP_W-1:0] temp_i,
   output logic [DW-1:0]     rd_word
);
   localparam logic [DW-1:0] FIELD_MASK = DW'((1 << FIELD_W) - 1);
   localparam logic [DW-1:0] TRIP_MASK  = FIELD_MASK & ~DW'((1 << TRIP_LSB) - 1);

   if (CAP_VAL[15:8] != 8'h00) begin : g_chk_cap
      $error("tsreg_file: capability upper byte must be zero");
   end
   if (TEMP_W > FIELD_W || TEMP_W < 2) begin : g_chk_tw
      $error("tsreg_file: TEMP_W out of range");
   end
   if (TRIP_LSB >= FIELD_W) begin : g_chk_trip
      $error("tsreg_file: TRIP_LSB out of range");
   end
   if (CFG_MASK[15:11] != 5'd0) begin : g_chk_cfg
      $error("tsreg_file: reserved config bits must not be writable");
   end

   logic [FIELD_W-1:0] tval;
   if (TEMP_W == FIELD_W) begin : g_temp_full
      assign tval = temp_i;
   end else begin : g_temp_ext
      assign tval = {{(FIELD_W-TEMP_W){temp_i[TEMP_W-1]}}, temp_i};
   end

   logic [DW-1:0] cfg_q, upr_q, lwr_q, crt_q, tmo_q;
   logic          f_crit, f_high, f_low;
   logic [DW-1:0] tmp_word;

   assign f_crit = $signed(tval) > $signed(crt_q[FIELD_W-1:0]);
   assign f_high = $signed(tval) > $signed(upr_q[FIELD_W-1:0]);
   assign f_low  = $signed(tval) < $signed(lwr_q[FIELD_W-1:0]);
   assign tmp_word = {f_crit, f_high, f_low, tval};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         upr_q <= '0;
         lwr_q <= '0;
         crt_q <= '0;
         tmo_q <= '0;
      end else if (wr_en) begin
         case (ptr)
            P_CFG:   cfg_q <= wr_data & CFG_MASK;
            P_UPR:   upr_q <= wr_data & TRIP_MASK;
            P_LWR:   lwr_q <= wr_data & TRIP_MASK;
            P_CRT:   crt_q <= wr_data & TRIP_MASK;
            P_TMO:   tmo_q <= wr_data & TMO_MASK;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (ptr)
         P_CAP:   rd_word = CAP_VAL;
         P_CFG:   rd_word = cfg_q;
         P_UPR:   rd_word = upr_q;
         P_LWR:   rd_word = lwr_q;
         P_CRT:   rd_word = crt_q;
         P_TMP:   rd_word = tmp_word;
         P_MFG:   rd_word = MFG_ID;
         P_TMO:   rd_word = tmo_q;
         default: rd_word = '0;
      endcase
   end

   logic wr_mapped;
   assign wr_mapped = (ptr == P_CFG) || (ptr == P_UPR) || (ptr == P_LWR) ||
                      (ptr == P_CRT) || (ptr == P_TMO);

   assert_ro_discard_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_mapped) |=>
      ($stable(cfg_q) && $stable(upr_q) && $stable(lwr_q) && $stable(crt_q) && $stable(tmo_q)));
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(cfg_q) && $stable(upr_q) && $stable(crt_q)));
   assert_cfg_rsv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[15:11] == 5'd0);
   assert_trip_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upr_q[TRIP_LSB-1:0] == '0) && (lwr_q[15:FIELD_W] == '0));
endmodule

// File: rtl/tsens_regif.sv
module tsens_regif
   import tsreg_pkg::*;
#(
   parameter int          SEL_W    = 3,
   parameter int          TEMP_W   = 13,
   parameter int          TRIP_LSB = 2,
   parameter logic [15:0] CAP_VAL  = 16'h0057,
   parameter logic [15:0] MFG_ID   = 16'h001F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  addr_sel_i,
   input  logic [TEMP_W-1:0] temp_i,
   input  logic              bus_start_i,
   input  logic              bus_stop_i,
   input  logic              rx_vld_i,
   input  logic [7:0]        rx_byte_i,
   output logic              rx_ack_o,
   input  logic              tx_take_i,
   output logic [7:0]        tx_byte_o
);
   localparam int PTR_W = 8;

   logic [PTR_W-1:0] ptr;
   logic             wr_en;
   logic [DW-1:0]    wr_data;
   logic [DW-1:0]    rd_word;

   tsreg_xact #(.PTR_W(PTR_W), .SEL_W(SEL_W)) u_xact (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel_i),
      .bus_start(bus_start_i), .bus_stop(bus_stop_i),
      .rx_vld(rx_vld_i), .rx_byte(rx_byte_i), .tx_take(tx_take_i),
      .rd_word(rd_word), .rx_ack(rx_ack_o), .tx_byte(tx_byte_o),
      .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data)
   );

   tsreg_file #(.PTR_W(PTR_W), .TEMP_W(TEMP_W), .TRIP_LSB(TRIP_LSB),
                .CAP_VAL(CAP_VAL), .MFG_ID(MFG_ID)) u_file (
      .clk(clk), .rst_n(rst_n), .ptr(ptr), .wr_en(wr_en),
      .wr_data(wr_data), .temp_i(temp_i), .rd_word(rd_word)
   );
endmodule

// File: tb/tsens_regif_bench.sv
module tsens_regif_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr_sel = 3'b101;
   logic [12:0] temp = '0;
   logic        bstart = 1'b0, bstop = 1'b0, rx_vld = 1'b0, tx_take = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_ack;
   logic [7:0]  tx_byte;

   int compared = 0, mismatched = 0;
   bit done = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   localparam logic [7:0] AW = 8'h3A;  // 0011_101_0
   localparam logic [7:0] AR = 8'h3B;

   always #5 clk = ~clk;

   tsens_regif u_tsens_regif (
      .clk(clk), .rst_n(rst_n), .addr_sel_i(addr_sel), .temp_i(temp),
      .bus_start_i(bstart), .bus_stop_i(bstop), .rx_vld_i(rx_vld),
      .rx_byte_i(rx_byte), .rx_ack_o(rx_ack), .tx_take_i(tx_take),
      .tx_byte_o(tx_byte)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compare transmitted bytes against the scoreboard queue
   always @(negedge clk) begin
      if (tx_take && !done) begin
         if (exp_q.size() == 0) begin
            check({8'h00, tx_byte}, 16'hDEAD, "R4 unexpected byte");
         end else begin
            check({8'h00, tx_byte}, {8'h00, exp_q.pop_front()}, tag_q.pop_front());
         end
      end
   end

   task automatic strobe_start();
      @(posedge clk); #1 bstart = 1'b1;
      @(posedge clk); #1 bstart = 1'b0;
   endtask
   task automatic strobe_stop();
      @(posedge clk); #1 bstop = 1'b1;
      @(posedge clk); #1 bstop = 1'b0;
   endtask
   task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
      @(posedge clk); #1 rx_vld = 1'b1; rx_byte = b;
      #3 check({15'd0, rx_ack}, {15'd0, exp_ack}, tag);
      @(posedge clk); #1 rx_vld = 1'b0;
   endtask
   task automatic take();
      @(posedge clk); #1 tx_take = 1'b1;
      @(posedge clk); #1 tx_take = 1'b0;
   endtask
   task automatic expect_word(input logic [15:0] w, input string tag);
      exp_q.push_back(w[15:8]); tag_q.push_back({tag, " msb"});
      exp_q.push_back(w[7:0]);  tag_q.push_back({tag, " lsb"});
   endtask
   task automatic write_reg(input logic [7:0] p, input logic [15:0] w, input string tag);
      strobe_start();
      send(AW, 1'b1, tag); send(p, 1'b1, tag);
      send(w[15:8], 1'b1, tag); send(w[7:0], 1'b1, tag);
      strobe_stop();
   endtask
   task automatic read_cur(input logic [15:0] exp, input string tag);
      strobe_start();
      send(AR, 1'b1, tag);
      expect_word(exp, tag);
      take(); take();
      strobe_stop();
   endtask
   task automatic read_reg(input logic [7:0] p, input logic [15:0] exp, input string tag);
      strobe_start();
      send(AW, 1'b1, tag); send(p, 1'b1, tag);
      strobe_start();
      send(AR, 1'b1, tag);
      expect_word(exp, tag);
      take(); take();
      strobe_stop();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         mismatched++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #4 check({8'h00, tx_byte}, 16'h00FF, "reset idle tx");
      // reset state: pointer 00h -> capability
      read_cur(16'h0057, "R2 R5 reset pointer capability");
      read_reg(8'h01, 16'h0000, "R6 config reset");
      read_reg(8'h02, 16'h0000, "R7 upper reset");
      read_reg(8'h04, 16'h0000, "R7 critical reset");
      read_reg(8'h22, 16'h0000, "R10 timeout reset");
      // config reserved bits
      write_reg(8'h01, 16'hFFFF, "R6 cfg write");
      read_reg(8'h01, 16'h07FF, "R6 cfg reserved zero");
      // trip masking
      write_reg(8'h03, 16'hFFFF, "R7 lower write");
      read_reg(8'h03, 16'h1FFC, "R7 lower masked");
      write_reg(8'h02, 16'h0190, "R7 upper 25C");
      write_reg(8'h03, 16'h00A0, "R7 lower 10C");
      write_reg(8'h04, 16'h0280, "R7 crit 40C");
      read_reg(8'h04, 16'h0280, "R3 crit readback");
      // temperature flags
      temp = 13'h01E0;
      read_reg(8'h05, 16'h41E0, "R8 30C above upper");
      temp = 13'h1FB0;
      read_cur(16'h3FB0, "R8 -5C below lower signed");
      temp = 13'h0320;
      read_cur(16'hC320, "R8 50C crit and upper");
      temp = 13'h0190;
      read_cur(16'h0190, "R8 equal upper no flag");
      temp = 13'h00A0;
      read_cur(16'h00A0, "R8 equal lower no flag");
      // snapshot at address acceptance
      temp = 13'h01E0;
      strobe_start();
      send(AR, 1'b1, "R4 snapshot addr");
      temp = 13'h0320;
      expect_word(16'h41E0, "R4 snapshot");
      take(); take();
      strobe_stop();
      // read-only and unmapped writes
      write_reg(8'h05, 16'hFFFF, "R11 temp write");
      read_cur(16'hC320, "R11 R8 temp unchanged");
      write_reg(8'h06, 16'h1234, "R11 mfg write");
      read_cur(16'h001F, "R9 manufacturer id");
      write_reg(8'h00, 16'hFFFF, "R11 cap write");
      read_cur(16'h0057, "R5 capability read-only");
      write_reg(8'h10, 16'hABCD, "R11 unmapped write");
      read_cur(16'h0000, "R11 unmapped reads zero");
      write_reg(8'h22, 16'hFFFF, "R10 timeout write");
      read_cur(16'h0080, "R10 only bit7");
      // address mismatch
      strobe_start();
      send(8'h5A, 1'b0, "R1 wrong type nack");
      send(8'h01, 1'b0, "R1 follow byte nack");
      send(8'h00, 1'b0, "R1 follow byte nack2");
      send(8'h00, 1'b0, "R1 follow byte nack3");
      strobe_stop();
      strobe_start();
      send(8'h38, 1'b0, "R1 wrong strap nack");
      strobe_stop();
      read_cur(16'h0080, "R1 R2 pointer untouched");
      // aborted write
      strobe_start();
      send(AW, 1'b1, "R12 abort addr");
      send(8'h01, 1'b1, "R12 abort ptr");
      send(8'h00, 1'b1, "R12 abort msb");
      strobe_stop();
      read_cur(16'h07FF, "R12 R2 cfg unchanged, ptr kept");
      // extra bytes
      strobe_start();
      send(AW, 1'b1, "R3 extra addr");
      send(8'h01, 1'b1, "R3 extra ptr");
      send(8'h01, 1'b1, "R3 extra msb");
      send(8'h23, 1'b1, "R3 extra lsb");
      send(8'h7F, 1'b1, "R3 extra byte acked");
      strobe_stop();
      read_cur(16'h0123, "R3 first two bytes kept");
      // read-direction byte after read: not acked
      strobe_start();
      send(AR, 1'b1, "R4 read addr");
      send(8'h55, 1'b0, "R4 rx during read nack");
      expect_word(16'h0123, "R4 after stray rx");
      take(); take();
      strobe_stop();
      repeat (4) @(posedge clk);
      if (exp_q.size() != 0) check(16'(exp_q.size()), 16'h0000, "R4 leftover bytes");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule